// File: doc/BRIEF.md
# Asynchronous SRAM Write-Readback Tester

This block exercises a sixteen-location window of an asynchronous static RAM through a 4-bit address, a 4-bit bidirectional data bus and two active-low strobes: one enables the memory's outputs and one enables writes. After a synchronous reset it fills every location with its own address value, in ascending order. It then reads the locations back in the same order and compares each one against its address.

A pacing tick, divided down from the system clock (by default 27,000,000 clocks, or one per second at 27 MHz), lets the sequence advance by only one location per tick. This keeps it slow enough for a person to follow on LEDs and a hex display. The block reports whether it is writing, reading, has failed or has passed. It also exposes the current address and data for the display. On the first mismatch it freezes on the failing address. Success or failure stays latched until the next reset.

The strobes are decoded from the next state and registered, so they come straight from flip-flops with no glitches. The write strobe has a state of its own, with address and data settled one clock before it and held one clock after it. The tester lets go of the data bus before it enables the memory outputs.

Top module: `sram_tester_top`

## Requirements
- R1: While reset is high and in the first clock after it falls, the address is 0, both strobes are high, writing is 1, reading, pass and fail are 0, and the display address is 0.
- R2: The write pass issues exactly sixteen write strobes, for addresses 0,1,...,15 in order, and drives the value N on the data bus during the strobe for address N.
- R3: The write strobe is low for exactly one clock. The address is unchanged in the clock before the strobe and in the clock after it. The output-enable strobe is high throughout.
- R4: Consecutive write strobes fall exactly TICK_DIV clocks apart, and so do consecutive falls of the output-enable strobe. The pacing tick is a single-clock pulse.
- R5: While the output-enable strobe is low, the tester does not drive the data bus. It has already released the bus in the clock before output enable falls.
- R6: For each read, output enable stays low for exactly two clocks. The bus is captured at the end of the second clock and compared with the address. The captured value appears on the display data in the next clock.
- R7: On the first mismatch, fail goes to 1 and reading goes to 0. The address freezes on the failing location and the display data holds the value that was read. This state stays until reset.
- R8: When all sixteen reads match, pass goes to 1 with the address held at 15, and it stays at 1 until reset.
- R9: At most one of writing, reading, pass and fail is 1 at any time. Writing is 1 during every write strobe and reading is 1 during every read.
- R10: The display address always equals the memory address. During the write pass the display data equals the value being written.
- R11: A reset in the middle of a run restarts the test from the write of address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, already debounced; starts the test |
| mem_addr | output | 4 | Address to the memory |
| mem_oe_n | output | 1 | Active-low memory output enable |
| mem_we_n | output | 1 | Active-low memory write enable |
| mem_dq | inout | 4 | Bidirectional data bus; driven only during the write pass |
| led_writing | output | 1 | Write pass in progress |
| led_reading | output | 1 | Read pass in progress |
| led_fail | output | 1 | Test failed (latched) |
| led_pass | output | 1 | Test passed (latched) |
| disp_addr | output | 4 | Address shown on the hex display |
| disp_data | output | 4 | Data shown on the hex display |

## Verification
The memory model in the bench is tried first healthy, which must give a pass, and then with one of three faults. The first fault holds the top data bit at zero, like a disconnected wire; the run must stop at address 8, the first location whose pattern uses that bit. The second fault corrupts only location 0 and the third corrupts only location 15. Together these show that the block stops at the first and the last locations and does not skip past a bad read. A reset in the middle of the read pass shows that the sequence starts over cleanly. In every run, strobe spacing, address hold around the write strobe and the captured read data are compared against a queue of expected accesses.

// File: rtl/sram_tester_pkg.sv
package sram_tester_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 4;
    localparam int LAST_LOC = (1 << ADDR_W) - 1;

    typedef enum logic [2:0] {
        ST_WR_WAIT,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_RD_WAIT,
        ST_RD_ENABLE,
        ST_RD_SAMPLE,
        ST_PASS,
        ST_FAIL
    } tst_state_e;

    typedef struct packed {
        logic we_n;
        logic oe_n;
        logic drive;
        logic writing;
        logic reading;
        logic pass;
        logic fail;
    } mem_ctrl_t;

    // Strobe and indicator levels that belong to each state.
    function automatic mem_ctrl_t ctrl_for(tst_state_e s);
        mem_ctrl_t c;
        c = '{we_n: 1'b1, oe_n: 1'b1, drive: 1'b0, writing: 1'b0,
              reading: 1'b0, pass: 1'b0, fail: 1'b0};
        case (s)
            ST_WR_WAIT, ST_WR_HOLD: begin
                c.drive   = 1'b1;
                c.writing = 1'b1;
            end
            ST_WR_STROBE: begin
                c.drive   = 1'b1;
                c.writing = 1'b1;
                c.we_n    = 1'b0;
            end
            ST_RD_WAIT:   c.reading = 1'b1;
            ST_RD_ENABLE, ST_RD_SAMPLE: begin
                c.reading = 1'b1;
                c.oe_n    = 1'b0;
            end
            ST_PASS:      c.pass = 1'b1;
            ST_FAIL:      c.fail = 1'b1;
            default:      ;
        endcase
        return c;
    endfunction

    // Test pattern: each location holds its own address.
    function automatic logic [DATA_W-1:0] pattern_for(logic [ADDR_W-1:0] a);
        return DATA_W'(a);
    endfunction

endpackage

// File: rtl/pace_ticker.sv
module pace_ticker #(
    parameter int TICK_DIV = 27_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    generate
        if (TICK_DIV > 1) begin : g_tick_chk
            // R4: tick is a single-clock pulse
            assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/tester_seq.sv
module tester_seq
    import sram_tester_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] rd_bus,
    output logic [ADDR_W-1:0] addr_q,
    output mem_ctrl_t         ctrl_q,
    output logic [DATA_W-1:0] rd_q
);
    tst_state_e        state_q, state_nxt;
    logic [ADDR_W-1:0] addr_nxt;
    logic              at_last;

    assign at_last = (addr_q == ADDR_W'(LAST_LOC));

    always_comb begin
        state_nxt = state_q;
        addr_nxt  = addr_q;
        case (state_q)
            ST_WR_WAIT:   if (tick) state_nxt = ST_WR_STROBE;
            ST_WR_STROBE: state_nxt = ST_WR_HOLD;
            ST_WR_HOLD: begin
                if (at_last) begin
                    state_nxt = ST_RD_WAIT;
                    addr_nxt  = '0;
                end else begin
                    state_nxt = ST_WR_WAIT;
                    addr_nxt  = addr_q + 1'b1;
                end
            end
            ST_RD_WAIT:   if (tick) state_nxt = ST_RD_ENABLE;
            ST_RD_ENABLE: state_nxt = ST_RD_SAMPLE;
            ST_RD_SAMPLE: begin
                if (rd_bus != pattern_for(addr_q)) begin
                    state_nxt = ST_FAIL;
                end else if (at_last) begin
                    state_nxt = ST_PASS;
                end else begin
                    state_nxt = ST_RD_WAIT;
                    addr_nxt  = addr_q + 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Strobes are registered from the next state so they leave flip-flops.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WR_WAIT;
            addr_q  <= '0;
            ctrl_q  <= ctrl_for(ST_WR_WAIT);
            rd_q    <= '0;
        end else begin
            state_q <= state_nxt;
            addr_q  <= addr_nxt;
            ctrl_q  <= ctrl_for(state_nxt);
            if (state_q == ST_RD_SAMPLE) rd_q <= rd_bus;
        end
    end

    // R3: write strobe lasts one clock with address held on both sides
    assert_we_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.we_n |=> ctrl_q.we_n && $stable(addr_q));
    assert_we_setup_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.we_n) |-> $stable(addr_q));
    assert_we_bus_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.we_n |-> ctrl_q.drive && ctrl_q.oe_n);
    // R5: bus released before and while outputs are enabled
    assert_oe_nodrive_R5: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.oe_n |-> !ctrl_q.drive);
    assert_bus_release_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.oe_n) |-> !$past(ctrl_q.drive));
    // R7: failure freezes the address
    assert_fail_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.fail |=> ctrl_q.fail && $stable(addr_q));
    // R8: pass is latched
    assert_pass_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pass |=> ctrl_q.pass && $stable(addr_q));
    // R9: indicators are mutually exclusive
    assert_status_excl_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_q.writing, ctrl_q.reading, ctrl_q.pass, ctrl_q.fail}));

endmodule

// File: rtl/sram_tester_top.sv
module sram_tester_top
    import sram_tester_pkg::*;
#(
    parameter int TICK_DIV = 27_000_000
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              led_writing,
    output logic              led_reading,
    output logic              led_fail,
    output logic              led_pass,
    output logic [ADDR_W-1:0] disp_addr,
    output logic [DATA_W-1:0] disp_data
);
    logic              tick;
    logic [ADDR_W-1:0] addr_q;
    mem_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] rd_q;

    pace_ticker #(.TICK_DIV(TICK_DIV)) u_ticker (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    tester_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .rd_bus (mem_dq),
        .addr_q (addr_q),
        .ctrl_q (ctrl_q),
        .rd_q   (rd_q)
    );

    assign mem_dq      = ctrl_q.drive ? pattern_for(addr_q) : {DATA_W{1'bz}};
    assign mem_addr    = addr_q;
    assign mem_oe_n    = ctrl_q.oe_n;
    assign mem_we_n    = ctrl_q.we_n;
    assign led_writing = ctrl_q.writing;
    assign led_reading = ctrl_q.reading;
    assign led_fail    = ctrl_q.fail;
    assign led_pass    = ctrl_q.pass;
    assign disp_addr   = addr_q;
    assign disp_data   = ctrl_q.writing ? pattern_for(addr_q) : rd_q;

endmodule

// File: tb/tb_sram_tester_top.sv
module tb_sram_tester_top;

    localparam int DIV = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    wire  [3:0] dq;
    logic [3:0] mem_addr;
    logic       mem_oe_n, mem_we_n;
    logic       led_writing, led_reading, led_fail, led_pass;
    logic [3:0] disp_addr, disp_data;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;

    always #5 clk = ~clk;

    sram_tester_top #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq(dq), .led_writing(led_writing),
        .led_reading(led_reading), .led_fail(led_fail), .led_pass(led_pass),
        .disp_addr(disp_addr), .disp_data(disp_data)
    );

    // ---------------- memory model with fault injection ----------------
    logic [3:0] mem_arr [16];
    logic [3:0] stuck_clear = 4'h0;
    int         fault_loc   = -1;
    logic [3:0] fault_xor   = 4'h0;
    logic [3:0] model_out;

    initial for (int i = 0; i < 16; i++) mem_arr[i] = 4'(~i);

    always @(posedge mem_we_n) if (!rst) mem_arr[mem_addr] = dq;

    always_comb model_out = (mem_arr[mem_addr] & ~stuck_clear) ^
                            ((int'(mem_addr) == fault_loc) ? fault_xor : 4'h0);

    assign dq = (!mem_oe_n) ? model_out : 4'bzzzz;

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        bit         is_wr;
        int         a;
        logic [3:0] d;
    } item_t;
    item_t sb[$];
    int    exp_fail_at;

    // Driver: expected accesses for the current fault setup.
    task automatic plan_run();
        sb.delete();
        exp_fail_at = -1;
        for (int n = 0; n < 16; n++) sb.push_back('{1'b1, n, 4'(n)});
        for (int n = 0; n < 16; n++) begin
            logic [3:0] v;
            v = (4'(n) & ~stuck_clear) ^ ((n == fault_loc) ? fault_xor : 4'h0);
            sb.push_back('{1'b0, n, v});
            if (v != 4'(n)) begin
                exp_fail_at = n;
                break;
            end
        end
    endtask

    // Monitor
    int         last_we = -1, last_oe = -1, oe_cnt = 0;
    logic       prev_we_n = 1'b1;
    logic [3:0] prev_addr = 4'h0;
    bit         chk_after_we = 0, chk_disp = 0;
    logic [3:0] we_addr, disp_exp;

    always @(negedge clk) begin
        if (rst) begin
            last_we = -1; last_oe = -1; oe_cnt = 0;
            chk_after_we = 0; chk_disp = 0; prev_we_n = 1'b1;
        end else begin
            if (chk_after_we) begin
                chk(mem_we_n === 1'b1, "R3", "we_n one clock", int'(mem_we_n), 1);
                chk(mem_addr === we_addr, "R3", "addr hold after strobe", int'(mem_addr), int'(we_addr));
                chk_after_we = 0;
            end
            if (chk_disp) begin
                chk(disp_data === disp_exp, "R6", "captured read shown", int'(disp_data), int'(disp_exp));
                chk_disp = 0;
            end
            chk(disp_addr === mem_addr, "R10", "display address", int'(disp_addr), int'(mem_addr));
            if (!mem_we_n) begin
                if (prev_we_n) begin
                    chk(mem_addr === prev_addr, "R3", "addr setup before strobe", int'(mem_addr), int'(prev_addr));
                    if (last_we >= 0) chk(cyc - last_we == DIV, "R4", "write spacing", cyc - last_we, DIV);
                    last_we = cyc;
                end
                chk(mem_oe_n === 1'b1, "R3", "oe_n high in write", int'(mem_oe_n), 1);
                chk(led_writing === 1'b1, "R9", "writing during strobe", int'(led_writing), 1);
                chk(disp_data === mem_addr, "R10", "display write data", int'(disp_data), int'(mem_addr));
                if (sb.size() == 0) chk(0, "R2", "unexpected write", int'(mem_addr), -1);
                else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(it.is_wr, "R2", "write order kind", 0, 1);
                    chk(int'(mem_addr) == it.a, "R2", "write address", int'(mem_addr), it.a);
                    chk(dq === it.d, "R2", "write data", int'(dq), int'(it.d));
                end
                chk_after_we = 1;
                we_addr = mem_addr;
            end
            if (!mem_oe_n) begin
                oe_cnt++;
                chk(led_reading === 1'b1, "R9", "reading during read", int'(led_reading), 1);
                chk(dq === model_out, "R5", "bus free of contention", int'(dq), int'(model_out));
                if (oe_cnt == 1) begin
                    if (last_oe >= 0) chk(cyc - last_oe == DIV, "R4", "read spacing", cyc - last_oe, DIV);
                    last_oe = cyc;
                end else if (oe_cnt == 2) begin
                    if (sb.size() == 0) chk(0, "R6", "unexpected read", int'(mem_addr), -1);
                    else begin
                        item_t it;
                        it = sb.pop_front();
                        chk(!it.is_wr, "R6", "read order kind", 1, 0);
                        chk(int'(mem_addr) == it.a, "R6", "read address", int'(mem_addr), it.a);
                        disp_exp = it.d;
                        chk_disp = 1;
                    end
                end else begin
                    chk(0, "R6", "oe_n low too long", oe_cnt, 2);
                end
            end else begin
                oe_cnt = 0;
            end
            prev_we_n = mem_we_n;
            prev_addr = mem_addr;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset();
        @(posedge clk); #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        plan_run();
        #1 rst = 1'b0;
        @(negedge clk);
        chk(mem_addr === 4'h0, "R1", "reset address", int'(mem_addr), 0);
        chk(mem_we_n === 1'b1 && mem_oe_n === 1'b1, "R1", "reset strobes", int'({mem_we_n, mem_oe_n}), 3);
        chk(led_writing === 1'b1, "R1", "reset writing", int'(led_writing), 1);
        chk({led_reading, led_pass, led_fail} === 3'b000, "R1", "reset indicators", int'({led_reading, led_pass, led_fail}), 0);
        chk(disp_addr === 4'h0, "R1", "reset display address", int'(disp_addr), 0);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (led_pass || led_fail) break;
        end
    endtask

    task automatic run_case(input string req);
        do_reset();
        wait_done();
        if (exp_fail_at < 0) begin
            chk(led_pass === 1'b1 && led_fail === 1'b0, "R8", {req, " pass"}, int'({led_pass, led_fail}), 2);
            chk(mem_addr === 4'hF, "R8", {req, " final address"}, int'(mem_addr), 15);
            chk(disp_data === 4'hF, "R8", {req, " final data"}, int'(disp_data), 15);
        end else begin
            chk(led_fail === 1'b1 && led_pass === 1'b0, "R7", {req, " fail"}, int'({led_fail, led_pass}), 2);
            chk(int'(mem_addr) == exp_fail_at, "R7", {req, " failing address"}, int'(mem_addr), exp_fail_at);
        end
        chk({led_reading, led_writing} === 2'b00, "R9", {req, " idle indicators"}, int'({led_reading, led_writing}), 0);
        repeat (30) @(negedge clk);
        chk(led_pass === (exp_fail_at < 0) && led_fail === (exp_fail_at >= 0), "R7", {req, " result latched"},
            int'({led_pass, led_fail}), (exp_fail_at < 0) ? 2 : 1);
        if (exp_fail_at >= 0)
            chk(int'(mem_addr) == exp_fail_at, "R7", {req, " address frozen"}, int'(mem_addr), exp_fail_at);
        chk(mem_we_n === 1'b1 && mem_oe_n === 1'b1, "R7", {req, " strobes idle"}, int'({mem_we_n, mem_oe_n}), 3);
        chk(sb.size() == 0, "R2", {req, " all accesses seen"}, sb.size(), 0);
    endtask

    initial begin
        // healthy memory (R2, R8)
        run_case("healthy");
        // top data bit stuck low: first failure at 8, read shows 0 (R7)
        stuck_clear = 4'h8;
        run_case("stuck bit3");
        chk(disp_data === 4'h0, "R7", "stuck bit3 read value shown", int'(disp_data), 0);
        stuck_clear = 4'h0;
        // corrupt first location (R7)
        fault_loc = 0; fault_xor = 4'h1;
        run_case("bad loc0");
        chk(disp_data === 4'h1, "R7", "loc0 read value shown", int'(disp_data), 1);
        // corrupt last location (R7)
        fault_loc = 15; fault_xor = 4'h8;
        run_case("bad loc15");
        chk(disp_data === 4'h7, "R7", "loc15 read value shown", int'(disp_data), 7);
        fault_loc = -1; fault_xor = 4'h0;
        // reset in the middle of the read pass (R11)
        do_reset();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (led_reading && mem_addr == 4'h5) break;
        end
        chk(led_reading === 1'b1, "R11", "reached read pass", int'(led_reading), 1);
        run_case("restart R11");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule